// File: doc/BRIEF.md
# Toggle-Kicked Watchdog Counter

This block supervises software with a 10-bit down-counter. The counter starts from its maximum value and steps down once per prescaled tick. When it passes zero, it has overflowed. If software has not refreshed it by then, the block drives a system reset pulse for a fixed number of clocks. After the pulse the counter starts a new period from its maximum value.

Software refreshes the counter by inverting one bit of a control register. A write that changes the bit's level, in either direction, reloads the counter to its maximum value and restarts the prescaler. A write that leaves the level unchanged does not count as a refresh.

A mask bit stops an overflow from causing a reset. With the mask set, the block is a fixed-interval timer: each overflow sets a sticky flag that software polls and clears. The count value itself is never visible to software.

Top module: `wdt_toggle_watchdog`

## Requirements
- R1: During and right after a synchronous active-low reset, `wd_rst` is low and `reg_rdata` reads 0.
- R2: With the mask clear and no refresh, `wd_rst` first goes high 1024 × PRESCALE clocks after reset is released.
- R3: Each reset pulse on `wd_rst` lasts exactly RST_LEN clocks.
- R4: A register write that changes the kick bit (bit 5) reloads the counter. A rising change and a falling change both count. The next overflow then comes 1024 × PRESCALE + 1 clocks after the write is sampled.
- R5: A write that leaves the kick bit at its current level is not a refresh and does not move the overflow.
- R6: With the mask bit (bit 0) set, an overflow gives no pulse on `wd_rst` and sets the flag (bit 7 of `reg_rdata`). With the mask clear, an overflow gives a pulse and leaves the flag alone.
- R7: The flag stays set until a write with bit 1 set. A write with bit 1 clear leaves the flag unchanged.
- R8: In masked mode, overflows repeat every 1024 × PRESCALE clocks with no refresh needed.
- R9: After a reset pulse ends, the counter restarts from its maximum value. The next pulse begins 1024 × PRESCALE clocks after the cycle in which the previous one ended.
- R10: `reg_rdata` returns the stored control bits, including the mask bit 0 and the kick bit 5. Bit 1 reads 0 and bit 7 is the flag. The count never appears.
- R11: If a refresh falls on the same clock as an overflow tick, the refresh wins: no pulse, and the counter reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Write data: bit 0 mask, bit 1 flag clear, bit 5 kick |
| reg_rdata | output | 8 | Read data: stored control bits, flag in bit 7 |
| wd_rst | output | 1 | Watchdog system reset pulse |

## Verification
The timeout is measured in several situations:
- from reset release;
- from a rising kick and from a falling kick;
- after a same-level write, which must not move the timeout;
- after a completed pulse, which must re-arm the counter.

Each of these predicts a different cycle, so a missing reload, a reload on any write, or a reload on one edge only shows up as a pulse at the wrong time. A kick timed to land on the overflow tick separates a refresh-first priority from a tick-first one. The masked runs poll the flag one cycle before and at each overflow, then clear it with bit 1 set and with bit 1 clear. This tells apart a sticky flag, a flag that the wrong write clears, and an overflow that still leaks onto the reset output.

// File: rtl/wdt_pkg.sv
// Package: shared constants for the toggle-kicked watchdog.
// Assumes an 8-bit control register; the field positions below are the
// software-visible layout.
package wdt_pkg;
    localparam int REG_W    = 8;
    localparam int MASK_BIT = 0;   // overflow does not reset when set
    localparam int CLR_BIT  = 1;   // write 1 clears the interval flag
    localparam int KICK_BIT = 5;   // any level change is a refresh
    localparam int FLAG_BIT = 7;   // read-only interval flag
    // Bits held in the control register (mask, kick and spare bits).
    localparam logic [REG_W-1:0] STORE_MASK =
        ~((REG_W'(1) << CLR_BIT) | (REG_W'(1) << FLAG_BIT));
endpackage

// File: rtl/wdt_prescaler.sv
// Module: tick prescaler.
// Produces a one-clock tick every DIV clocks. 'clear' restarts the
// division and suppresses the tick in that cycle.
// Assumes DIV >= 1.
module wdt_prescaler #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV == 1) begin : g_direct
            // Every clock is a tick unless cleared.
            assign tick = !clear;
        end else begin : g_div
            logic [PW-1:0] div_q;

            // Divider counter: wraps on tick, restarts on clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    div_q <= '0;
                end else if (clear || tick) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end

            assign tick = !clear && (div_q == PW'(DIV - 1));

            // R2: the divider never leaves its range.
            a_r2_div_range: assert property (@(posedge clk) disable iff (!rst_n)
                div_q <= PW'(DIV - 1));
            // R4: a clear restarts the division.
            a_r4_clear_restart: assert property (@(posedge clk) disable iff (!rst_n)
                clear |=> (div_q == '0));
        end
    endgenerate
endmodule

// File: rtl/wdt_kick_detect.sv
// Module: refresh detector.
// Flags a refresh in any cycle where the kick level differs from its
// value one clock earlier, whether it rose or fell.
// Assumes the kick level resets to 0.
module wdt_kick_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_level,
    output logic refresh
);
    logic prev_q;

    // Delay the kick level by one clock for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= kick_level;
        end
    end

    assign refresh = kick_level ^ prev_q;

    // R5: a steady kick level never produces a refresh.
    a_r5_steady_no_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(kick_level) |-> !refresh);
    // R4: a change in either direction produces a refresh.
    a_r4_change_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(kick_level) |-> refresh);
endmodule

// File: rtl/wdt_countdown.sv
// Module: fixed-modulus down-counter.
// Counts down one step per tick from all-ones. 'ovf' pulses on the tick
// seen at zero, and the counter then reloads to all-ones. 'reload' has
// priority over a tick.
// Assumes the caller gates tick off in reload cycles.
module wdt_countdown #(
    parameter int CNT_W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic reload,
    output logic ovf
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] cnt_q;

    // Count state: reload wins, otherwise step down or wrap on tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= TOP;
        end else if (reload) begin
            cnt_q <= TOP;
        end else if (tick) begin
            cnt_q <= (cnt_q == '0) ? TOP : cnt_q - 1'b1;
        end
    end

    assign ovf = tick && (cnt_q == '0);

    // R4: a reload leaves the counter at its top value.
    a_r4_reload_top: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cnt_q == TOP));
    // R2: a tick above zero steps down by exactly one.
    a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !reload && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
    // R9: an overflow restarts the period from the top.
    a_r9_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !reload) |=> (cnt_q == TOP));
    // R11: no overflow is reported in a reload cycle.
    a_r11_reload_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        reload |-> !ovf);
endmodule

// File: rtl/wdt_pulse.sv
// Module: reset pulse stretcher.
// Starts a LEN-clock pulse on 'fire'.
// Assumes 'fire' does not arrive while a pulse is running.
module wdt_pulse #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic active
);
    localparam int LW = $clog2(LEN + 1);

    logic [LW-1:0] left_q;

    // Remaining pulse length: loaded on fire, counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (fire) begin
            left_q <= LW'(LEN);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign active = (left_q != '0);

    // R3: a fire raises the pulse on the next clock.
    a_r3_fire_starts: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> active);
    // R3: the pulse drops right after its last cycle.
    a_r3_last_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (left_q == LW'(1) && !fire) |=> !active);
endmodule

// File: rtl/wdt_regs.sv
// Module: control register and sticky interval flag.
// Holds the mask, kick and spare bits written by software. Keeps the flag
// that masked overflows set and that a write with the clear bit resets;
// a set in the same cycle as a clear wins.
module wdt_regs
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             ovf,
    output logic             mask,
    output logic             kick,
    output logic [REG_W-1:0] rdata
);
    logic [REG_W-1:0] ctl_q;
    logic             flag_q;

    // Control bits: take the written value, minus the strobe and flag bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr) begin
            ctl_q <= wdata & STORE_MASK;
        end
    end

    // Sticky flag: set by a masked overflow, cleared by a write with bit 1 set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (ovf && mask) begin
            flag_q <= 1'b1;
        end else if (wr && wdata[CLR_BIT]) begin
            flag_q <= 1'b0;
        end
    end

    assign mask = ctl_q[MASK_BIT];
    assign kick = ctl_q[KICK_BIT];

    // Read path: stored bits with the flag merged in.
    always_comb begin
        rdata           = ctl_q & STORE_MASK;
        rdata[FLAG_BIT] = flag_q;
    end

    // R6: a masked overflow sets the flag.
    a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && mask) |=> flag_q);
    // R7: without a clearing write, a set flag stays set.
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr && wdata[CLR_BIT])) |=> flag_q);
    // R6: an unmasked overflow does not set the flag.
    a_r6_unmasked_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && ovf && !mask) |=> !flag_q);
endmodule

// File: rtl/wdt_toggle_watchdog.sv
// Module: toggle-kicked watchdog (top).
// Prescaler ticks drive a CNT_W-bit down-counter. A change of the kick bit
// reloads the counter and the prescaler. An overflow either fires a RST_LEN
// reset pulse or, when masked, sets a poll flag. While the pulse runs, the
// counter and prescaler are held at their start values.
// Assumes one clock domain and software access through a write strobe.
module wdt_toggle_watchdog
    import wdt_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int PRESCALE = 16,
    parameter int RST_LEN  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             wd_rst
);
    logic mask, kick, refresh, hold, restart, tick, ovf, fire;

    wdt_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .ovf   (ovf),
        .mask  (mask),
        .kick  (kick),
        .rdata (reg_rdata)
    );

    wdt_kick_detect u_kick (
        .clk        (clk),
        .rst_n      (rst_n),
        .kick_level (kick),
        .refresh    (refresh)
    );

    // The counter restarts on a refresh and is held while a pulse runs.
    assign hold    = wd_rst;
    assign restart = refresh || hold;

    wdt_prescaler #(.DIV(PRESCALE)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart),
        .tick  (tick)
    );

    wdt_countdown #(.CNT_W(CNT_W)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .reload (restart),
        .ovf    (ovf)
    );

    assign fire = ovf && !mask;

    wdt_pulse #(.LEN(RST_LEN)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (fire),
        .active (wd_rst)
    );

    // R6: a masked overflow never raises the reset output.
    a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && mask) |=> !wd_rst);
    // R2: an unmasked overflow raises the reset output.
    a_r2_overflow_resets: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !mask) |=> wd_rst);
    // R9: no overflow while a pulse is running.
    a_r9_no_ovf_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst |-> !ovf);
endmodule

// File: tb/wdt_toggle_watchdog_test.sv
`timescale 1ns/1ps
module wdt_toggle_watchdog_test;
    localparam int P  = 4;
    localparam int RL = 4;
    localparam int T  = 1024 * P;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       wd_rst;

    always #4 clk = ~clk;   // 125 MHz

    wdt_toggle_watchdog #(.PRESCALE(P), .RST_LEN(RL)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .wd_rst    (wd_rst)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    int    q_cyc[$];
    string q_tag[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Scoreboard push: expected cycle in which wd_rst is first seen high.
    task automatic expect_rise(input int c, input string tag);
        q_cyc.push_back(c);
        q_tag.push_back(tag);
    endtask

    // Monitor: pops expected rises and checks pulse length.
    logic prev_wd = 1'b0;
    int   rise_at = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (wd_rst && !prev_wd) begin
                if (q_cyc.size() == 0) begin
                    check(1'b0, "R2 unexpected pulse", cyc, -1);
                end else begin
                    check(cyc == q_cyc[0], q_tag[0], cyc, q_cyc[0]);
                    void'(q_cyc.pop_front());
                    void'(q_tag.pop_front());
                end
                rise_at = cyc;
            end
            if (!wd_rst && prev_wd) check(cyc - rise_at == RL, "R3 pulse length", cyc - rise_at, RL);
            if (q_cyc.size() > 0 && cyc > q_cyc[0]) begin
                check(1'b0, {q_tag[0], " missed"}, cyc, q_cyc[0]);
                void'(q_cyc.pop_front());
                void'(q_tag.pop_front());
            end
        end
        prev_wd = wd_rst;
    end

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Driver: one-cycle write; c returns the cycle before the sampling edge.
    task automatic write_reg(input logic [7:0] d, output int c);
        c = cyc;
        reg_wr = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_wdata = 8'h00;
    endtask

    initial begin
        int c0, c, c2, c3, c4, c5, o, f, e1;
        repeat (5) @(negedge clk);
        check(reg_rdata == 8'h00, "R1 rdata in reset", reg_rdata, 0);
        check(wd_rst == 1'b0, "R1 wd_rst in reset", wd_rst, 0);
        c0 = cyc;
        rst_n = 1'b1;
        @(negedge clk);
        check(reg_rdata == 8'h00, "R1 rdata after reset", reg_rdata, 0);
        e1 = c0 + T;
        expect_rise(e1, "R2 first timeout");
        expect_rise(e1 + RL + T, "R9 rearm after pulse");
        wait_until(e1 + RL + T + RL + 2);

        // R4 rising kick, R5 same-level write, R10 readback
        write_reg(8'h20, c);
        expect_rise(c + 2 + T, "R4 rising kick");
        check(reg_rdata == 8'h20, "R10 kick readback", reg_rdata, 8'h20);
        wait_until(c + 1000);
        write_reg(8'h20, c2);   // R5: no level change, timeout must not move
        wait_until(c + 2 + T + RL + 10);
        write_reg(8'h00, c3);
        expect_rise(c3 + 2 + T, "R4 falling kick");
        wait_until(c3 + 2 + T + RL + 5);

        // R11: refresh on the same edge as the overflow tick
        write_reg(8'h20, c4);
        o = c4 + 2 + T;
        wait_until(o - 2);
        write_reg(8'h00, c5);
        expect_rise(c5 + 2 + T, "R11 collision reload");
        wait_until(o);
        check(wd_rst == 1'b0, "R11 no pulse at collision", wd_rst, 0);
        wait_until(o + T + RL + 3);

        // R6/R7/R8 masked interval timer
        f = o + T + RL;
        write_reg(8'h01, c);
        check(reg_rdata == 8'h01, "R10 mask readback", reg_rdata, 8'h01);
        wait_until(f + T - 1);
        check(reg_rdata[7] == 1'b0, "R6 flag before overflow", reg_rdata[7], 0);
        wait_until(f + T);
        check(reg_rdata[7] == 1'b1, "R6 flag at overflow", reg_rdata[7], 1);
        check(wd_rst == 1'b0, "R6 masked no pulse", wd_rst, 0);
        wait_until(f + T + 10);
        write_reg(8'h01, c);
        check(reg_rdata[7] == 1'b1, "R7 flag kept without clear bit", reg_rdata[7], 1);
        write_reg(8'h03, c);
        check(reg_rdata == 8'h01, "R7 flag cleared, bit1 reads 0", reg_rdata, 8'h01);
        wait_until(f + 2 * T - 1);
        check(reg_rdata[7] == 1'b0, "R8 flag before second interval", reg_rdata[7], 0);
        wait_until(f + 2 * T);
        check(reg_rdata[7] == 1'b1, "R8 flag at second interval", reg_rdata[7], 1);

        // R6: unmasked again, overflow resets and leaves flag clear
        wait_until(f + 2 * T + 5);
        write_reg(8'h02, c);
        expect_rise(f + 3 * T, "R6 unmasked overflow");
        wait_until(f + 3 * T + RL + 3);
        check(reg_rdata[7] == 1'b0, "R6 unmasked no flag", reg_rdata[7], 0);
        check(q_cyc.size() == 0, "R2 expected pulses all seen", q_cyc.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "R2 watchdog expired", cyc, -1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule